// File: doc/BRIEF.md
# Receive Status Channel Generator

This block drives the two-bit-per-cycle status stream that a packet ingress port returns to its upstream transmitter on a high-rate packet interface. While the data channel is in sync, it sends framed calendar sequences. Each sequence opens with a framing word and carries the two-bit FIFO status of the ports named by the active calendar. The calendar is walked a programmable number of times. The frame closes with a DIP-2 parity word. After a programmable number of frames, it can insert a block of status training.

While the data channel is out of sync, the block sends a fill pattern. The pattern depends on the electrical signalling mode given by a mode pin. In one mode it is a constant all-ones word. In the other it is the status training pattern.

An optional dual-calendar mode lets the receiver tell the transmitter which of two calendars is in force. It does this by sending a selection word in the slot directly after the framing word. All changes of mode, sync state and calendar configuration take effect only at unit or frame boundaries. The stream therefore never carries a truncated frame.

Top module: `rxStatusGen`

## Requirements
- R1: `modeFlag` shows the level of `lvdsMode` one clock after that level is sampled. It reads 0 in reset.
- R2: Consider a fill unit that starts while `lvdsMode` is low and `inSync` is low. Every word of that unit is 2'b11.
- R3: A fill unit is 20 words long. If it starts while `lvdsMode` is high, it carries ten words of 2'b00 and then ten words of 2'b11. The mode is sampled only when a unit starts, so a change part-way through a unit leaves the rest of that unit unchanged.
- R4: When `inSync` rises, the fill unit in progress completes before the framing word. When `inSync` falls, the frame in progress completes through its DIP word before fill starts.
- R5: A frame is the word 2'b11, then an optional selection word, then calLen×calRepeat entries, then one DIP word. Entry k is the status of the port numbered by calendar slot (k mod calLen). Port p's status sits at `portStatus[2p+1:2p]`, and slot j holds a 3-bit port number at bits [3j+2:3j] of its calendar vector.
- R6: The DIP word is the bitwise complement of the XOR of every word sent after the framing word. The selection word is included. As a result, the XOR of those words and the DIP word is 2'b11.
- R7: With `dualCalEn` high, the word after framing is 2'b01 and calendar 0 is used when `calSel` is 0. It is 2'b10 and calendar 1 is used when `calSel` is 1. With `dualCalEn` low, no selection word is sent and calendar 0 is used whatever `calSel` is.
- R8: `calSel`, `dualCalEn`, `calLen`, `calRepeat` and `trainReps` are sampled when a frame starts. A change during a frame first affects the next frame.
- R9: With `trainInterval` N nonzero, every Nth frame's DIP word is followed directly by `trainReps` repetitions of ten 2'b00 and ten 2'b11, and then the next frame starts. With N equal to 0, frames follow each other back to back.
- R10: While `rstN` is low, `statOut` is 2'b11. After reset, the first fill unit is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Status clock |
| rstN | input | 1 | Active-low synchronous reset |
| inSync | input | 1 | Ingress data channel is in sync |
| lvdsMode | input | 1 | Mode pin: 1 selects training fill, 0 selects all-ones fill |
| modeFlag | output | 1 | Registered copy of the mode pin |
| dualCalEn | input | 1 | Enables the two-calendar mode with a selection word |
| calSel | input | 1 | Chooses calendar 1 when set (dual mode only) |
| calLen | input | 5 | Calendar length in slots (0 treated as 1, clamped to 16) |
| calRepeat | input | 4 | Calendar passes per frame (0 treated as 1) |
| trainInterval | input | 8 | Frames between training blocks; 0 disables training |
| trainReps | input | 4 | Training pattern repetitions per block (0 treated as 1) |
| portStatus | input | 16 | Two-bit FIFO status per port |
| cal0Entries | input | 48 | Calendar 0 port numbers, 3 bits per slot |
| cal1Entries | input | 48 | Calendar 1 port numbers, 3 bits per slot |
| statOut | output | 2 | Status word stream |

## Verification
Suppose the slot counter, entry index or repeat counter drifts. The frame then has the wrong length, and the next framing word lands where an entry or the DIP word belongs. A faulty DIP accumulator shows up in the parity word of the very frame it corrupts. A wrongly latched calendar select shows up one cycle after framing, as a swapped selection word or as entries read from the other calendar. A boundary fault in the fill or training logic moves the 00/11 run edges off multiples of ten words within one unit, so each error can be seen within a frame or a 20-word unit of its cause.

// File: rtl/rxStatusPkg.sv
package rxStatusPkg;

  // Word kinds the control asks the datapath to emit in the next cycle.
  typedef enum logic [2:0] {
    K_ONES,
    K_ZEROS,
    K_FRAME,
    K_SEL,
    K_ENTRY,
    K_DIP
  } wordKind_e;

  typedef struct packed {
    wordKind_e kind;
    logic      useCal1;
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    S_FILL,
    S_FRAME,
    S_SEL,
    S_ENTRY,
    S_DIP,
    S_TRAIN
  } genState_e;

  // One fill or training unit: a run of zeros then a run of ones.
  localparam int unsigned RUN_LEN  = 10;
  localparam int unsigned UNIT_LEN = 2 * RUN_LEN;

endpackage

// File: rtl/rxStatusCtrl.sv
module rxStatusCtrl
  import rxStatusPkg::*;
#(
  parameter int CAL_MAX = 16,
  parameter int LEN_W   = 5,
  parameter int IDX_W   = 4,
  parameter int REP_W   = 4,
  parameter int FCNT_W  = 8,
  parameter int TREP_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inSync,
  input  logic              lvdsMode,
  input  logic              dualCalEn,
  input  logic              calSel,
  input  logic [LEN_W-1:0]  calLen,
  input  logic [REP_W-1:0]  calRepeat,
  input  logic [FCNT_W-1:0] trainInterval,
  input  logic [TREP_W-1:0] trainReps,
  output logic [IDX_W-1:0]  entryIdx,
  output ctrlStrobe_t       strobe,
  output logic              modeFlag
);

  localparam int SLOT_W = $clog2(UNIT_LEN);

  genState_e          state, stateNxt;
  logic [SLOT_W-1:0]  slotCnt, slotNxt;
  logic [IDX_W-1:0]   idxNxt;
  logic [REP_W-1:0]   repCnt, repNxt;
  logic [FCNT_W-1:0]  frameCnt, fcNxt;
  logic [TREP_W-1:0]  trainCnt, tcNxt;
  logic               fillLvds;
  logic               curSel, curDual;
  logic [LEN_W-1:0]   curLen;
  logic [REP_W-1:0]   curRep;
  logic [TREP_W-1:0]  curTrep;
  logic               latchFrame, latchFill;
  logic [LEN_W-1:0]   lenEff;
  logic [REP_W-1:0]   repEff;
  logic [TREP_W-1:0]  trepEff;
  logic               unitEnd, zeroRun;

  assign lenEff  = (calLen == '0) ? LEN_W'(1) :
                   (calLen > LEN_W'(CAL_MAX)) ? LEN_W'(CAL_MAX) : calLen;
  assign repEff  = (calRepeat == '0) ? REP_W'(1) : calRepeat;
  assign trepEff = (trainReps == '0) ? TREP_W'(1) : trainReps;
  assign unitEnd = (slotCnt == SLOT_W'(UNIT_LEN - 1));
  assign zeroRun = (slotCnt < SLOT_W'(RUN_LEN));

  always_comb begin
    stateNxt   = state;
    slotNxt    = slotCnt;
    idxNxt     = entryIdx;
    repNxt     = repCnt;
    fcNxt      = frameCnt;
    tcNxt      = trainCnt;
    latchFrame = 1'b0;
    latchFill  = 1'b0;
    unique case (state)
      S_FILL: begin
        if (unitEnd) begin
          slotNxt = '0;
          if (inSync) begin
            stateNxt   = S_FRAME;
            latchFrame = 1'b1;
          end else begin
            latchFill = 1'b1;
          end
        end else begin
          slotNxt = slotCnt + SLOT_W'(1);
        end
      end
      S_FRAME: begin
        idxNxt   = '0;
        repNxt   = '0;
        stateNxt = curDual ? S_SEL : S_ENTRY;
      end
      S_SEL: stateNxt = S_ENTRY;
      S_ENTRY: begin
        if (LEN_W'(entryIdx) + LEN_W'(1) == curLen) begin
          idxNxt = '0;
          if (repCnt + REP_W'(1) == curRep) stateNxt = S_DIP;
          else repNxt = repCnt + REP_W'(1);
        end else begin
          idxNxt = entryIdx + IDX_W'(1);
        end
      end
      S_DIP: begin
        slotNxt = '0;
        tcNxt   = '0;
        if (!inSync) begin
          stateNxt  = S_FILL;
          fcNxt     = '0;
          latchFill = 1'b1;
        end else if (trainInterval != '0 &&
                     frameCnt + FCNT_W'(1) >= trainInterval) begin
          stateNxt = S_TRAIN;
          fcNxt    = '0;
        end else begin
          stateNxt   = S_FRAME;
          fcNxt      = frameCnt + FCNT_W'(1);
          latchFrame = 1'b1;
        end
      end
      S_TRAIN: begin
        if (unitEnd) begin
          slotNxt = '0;
          if (trainCnt + TREP_W'(1) == curTrep) begin
            if (inSync) begin
              stateNxt   = S_FRAME;
              latchFrame = 1'b1;
            end else begin
              stateNxt  = S_FILL;
              latchFill = 1'b1;
            end
          end else begin
            tcNxt = trainCnt + TREP_W'(1);
          end
        end else begin
          slotNxt = slotCnt + SLOT_W'(1);
        end
      end
      default: stateNxt = S_FILL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_FILL;
      slotCnt  <= '0;
      entryIdx <= '0;
      repCnt   <= '0;
      frameCnt <= '0;
      trainCnt <= '0;
      fillLvds <= 1'b0;
      curSel   <= 1'b0;
      curDual  <= 1'b0;
      curLen   <= LEN_W'(1);
      curRep   <= REP_W'(1);
      curTrep  <= TREP_W'(1);
      modeFlag <= 1'b0;
    end else begin
      state    <= stateNxt;
      slotCnt  <= slotNxt;
      entryIdx <= idxNxt;
      repCnt   <= repNxt;
      frameCnt <= fcNxt;
      trainCnt <= tcNxt;
      modeFlag <= lvdsMode;
      if (latchFill) fillLvds <= lvdsMode;
      if (latchFrame) begin
        curSel  <= calSel;
        curDual <= dualCalEn;
        curLen  <= lenEff;
        curRep  <= repEff;
        curTrep <= trepEff;
      end
    end
  end

  always_comb begin
    strobe.useCal1 = curDual & curSel;
    unique case (state)
      S_FILL:  strobe.kind = (fillLvds && zeroRun) ? K_ZEROS : K_ONES;
      S_TRAIN: strobe.kind = zeroRun ? K_ZEROS : K_ONES;
      S_FRAME: strobe.kind = K_FRAME;
      S_SEL:   strobe.kind = K_SEL;
      S_ENTRY: strobe.kind = K_ENTRY;
      S_DIP:   strobe.kind = K_DIP;
      default: strobe.kind = K_ONES;
    endcase
  end

  // R5: the entry index never walks past the latched calendar length
  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ENTRY) |-> (LEN_W'(entryIdx) < curLen));

  // R3: fill mode is held for the whole unit
  assert_fill_mode_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FILL && !unitEnd) |=> $stable(fillLvds));

  // R4: once entries start, the frame runs to its DIP word whatever inSync does
  assert_frame_complete_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ENTRY) |=> (state == S_ENTRY || state == S_DIP));

  // R8: calendar choice and length are frozen inside a frame
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SEL || state == S_ENTRY) |=> ($stable(curSel) && $stable(curLen)));

  // R9: training only ever starts right after a DIP word
  assert_train_after_dip_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == S_TRAIN) |-> ($past(state) == S_DIP));

endmodule

// File: rtl/rxStatusDatapath.sv
module rxStatusDatapath
  import rxStatusPkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int CAL_MAX   = 16,
  parameter int PORT_W    = 3,
  parameter int IDX_W     = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strobe,
  input  logic [IDX_W-1:0]            entryIdx,
  input  logic [2*NUM_PORTS-1:0]      portStatus,
  input  logic [CAL_MAX*PORT_W-1:0]   cal0Entries,
  input  logic [CAL_MAX*PORT_W-1:0]   cal1Entries,
  output logic [1:0]                  statOut
);

  localparam int SLOTS = 1 << PORT_W;

  logic [2*SLOTS-1:0] statusPadded;
  logic [PORT_W-1:0]  portIdx;
  logic [1:0]         portVal, word, dipAcc;

  always_comb begin
    statusPadded = '0;
    statusPadded[2*NUM_PORTS-1:0] = portStatus;
  end

  assign portIdx = strobe.useCal1 ? cal1Entries[entryIdx*PORT_W +: PORT_W]
                                  : cal0Entries[entryIdx*PORT_W +: PORT_W];
  assign portVal = statusPadded[portIdx*2 +: 2];

  always_comb begin
    unique case (strobe.kind)
      K_ZEROS: word = 2'b00;
      K_SEL:   word = strobe.useCal1 ? 2'b10 : 2'b01;
      K_ENTRY: word = portVal;
      K_DIP:   word = ~dipAcc;
      default: word = 2'b11;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statOut <= 2'b11;
      dipAcc  <= 2'b00;
    end else begin
      statOut <= word;
      if (strobe.kind == K_FRAME) dipAcc <= 2'b00;
      else if (strobe.kind == K_SEL || strobe.kind == K_ENTRY) dipAcc <= dipAcc ^ word;
    end
  end

  // Observation of the emitted stream, used only by the checks below.
  wordKind_e  lastKind;
  logic [1:0] outXor;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastKind <= K_ONES;
      outXor   <= 2'b00;
    end else begin
      lastKind <= strobe.kind;
      if (lastKind == K_FRAME) outXor <= 2'b00;
      else if (lastKind == K_SEL || lastKind == K_ENTRY) outXor <= outXor ^ statOut;
    end
  end

  // R5: every frame opens with the framing word
  assert_frame_word_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lastKind == K_FRAME) |-> (statOut == 2'b11));

  // R6: parity over the emitted payload plus the DIP word is all ones
  assert_dip_parity_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lastKind == K_DIP) |-> ((outXor ^ statOut) == 2'b11));

  // R7: the selection word is one of the two legal codes
  assert_sel_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lastKind == K_SEL) |-> (statOut == 2'b01 || statOut == 2'b10));

endmodule

// File: rtl/rxStatusGen.sv
module rxStatusGen
  import rxStatusPkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int CAL_MAX   = 16,
  parameter int REP_W     = 4,
  parameter int FCNT_W    = 8,
  parameter int TREP_W    = 4,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int IDX_W    = (CAL_MAX > 1) ? $clog2(CAL_MAX) : 1,
  localparam int LEN_W    = $clog2(CAL_MAX + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inSync,
  input  logic                        lvdsMode,
  output logic                        modeFlag,
  input  logic                        dualCalEn,
  input  logic                        calSel,
  input  logic [LEN_W-1:0]            calLen,
  input  logic [REP_W-1:0]            calRepeat,
  input  logic [FCNT_W-1:0]           trainInterval,
  input  logic [TREP_W-1:0]           trainReps,
  input  logic [2*NUM_PORTS-1:0]      portStatus,
  input  logic [CAL_MAX*PORT_W-1:0]   cal0Entries,
  input  logic [CAL_MAX*PORT_W-1:0]   cal1Entries,
  output logic [1:0]                  statOut
);

  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] entryIdx;

  rxStatusCtrl #(
    .CAL_MAX(CAL_MAX), .LEN_W(LEN_W), .IDX_W(IDX_W),
    .REP_W(REP_W), .FCNT_W(FCNT_W), .TREP_W(TREP_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .inSync(inSync), .lvdsMode(lvdsMode),
    .dualCalEn(dualCalEn), .calSel(calSel), .calLen(calLen),
    .calRepeat(calRepeat), .trainInterval(trainInterval),
    .trainReps(trainReps), .entryIdx(entryIdx), .strobe(strobe),
    .modeFlag(modeFlag)
  );

  rxStatusDatapath #(
    .NUM_PORTS(NUM_PORTS), .CAL_MAX(CAL_MAX), .PORT_W(PORT_W), .IDX_W(IDX_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .entryIdx(entryIdx),
    .portStatus(portStatus), .cal0Entries(cal0Entries),
    .cal1Entries(cal1Entries), .statOut(statOut)
  );

endmodule

// File: tb/tb_rxStatusGen.sv
module tb_rxStatusGen;
  localparam int NP = 8;
  localparam int CM = 16;
  localparam int PW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, inSync = 1'b0, lvdsMode = 1'b0, dualCalEn = 1'b0, calSel = 1'b0;
  logic [4:0] calLen = 5'd1;
  logic [3:0] calRepeat = 4'd1, trainReps = 4'd1;
  logic [7:0] trainInterval = 8'd0;
  logic [2*NP-1:0] portStatus;
  logic [CM*PW-1:0] cal0Entries, cal1Entries;
  logic modeFlag;
  logic [1:0] statOut;

  logic [1:0] pst [NP];
  int calA [CM];
  int calB [CM];

  always_comb begin
    for (int p = 0; p < NP; p++) portStatus[2*p +: 2] = pst[p];
    for (int k = 0; k < CM; k++) begin
      cal0Entries[k*PW +: PW] = PW'(calA[k]);
      cal1Entries[k*PW +: PW] = PW'(calB[k]);
    end
  end

  rxStatusGen dut (
    .clk(clk), .rstN(rstN), .inSync(inSync), .lvdsMode(lvdsMode),
    .modeFlag(modeFlag), .dualCalEn(dualCalEn), .calSel(calSel),
    .calLen(calLen), .calRepeat(calRepeat), .trainInterval(trainInterval),
    .trainReps(trainReps), .portStatus(portStatus), .cal0Entries(cal0Entries),
    .cal1Entries(cal1Entries), .statOut(statOut)
  );

  logic [1:0] logW [4096];
  int logN = 0;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always @(negedge clk) begin
    cyc++;
    if (rstN && logN < 4096) begin
      logW[logN] = statOut;
      logN++;
    end
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitLog(input int n);
    while (logN < n) @(negedge clk);
  endtask

  task automatic doReset(input bit sync, input bit lvds, input bit dual, input bit sel,
                         input int len, input int rep, input int tint, input int treps);
    @(negedge clk);
    #1;
    rstN = 1'b0;
    inSync = sync; lvdsMode = lvds; dualCalEn = dual; calSel = sel;
    calLen = 5'(len); calRepeat = 4'(rep);
    trainInterval = 8'(tint); trainReps = 4'(treps);
    repeat (3) @(negedge clk);
    // R10: reset state of the stream and the mode flag
    check(statOut == 2'b11, "R10", "statOut in reset", int'(statOut), 3);
    check(modeFlag == 1'b0, "R10", "modeFlag in reset", int'(modeFlag), 0);
    #1;
    rstN = 1'b1;
    logN = 0;
  endtask

  function automatic int frameStart(input int from);
    bit seen = 1'b0;
    for (int i = from; i < logN; i++) begin
      if (logW[i] == 2'b11) seen = 1'b1;
      else if (seen) return i - 1;
    end
    return -1;
  endfunction

  task automatic checkFrame(input int s, input bit dual, input bit sel, input int len,
                            input int rep, output int nxt);
    int i = s;
    int errs = 0;
    int firstBad = -1;
    logic [1:0] acc = 2'b00;
    logic [1:0] exp;
    check(logW[i] == 2'b11, "R5", "framing word", int'(logW[i]), 3);
    i++;
    if (dual) begin
      exp = sel ? 2'b10 : 2'b01;
      check(logW[i] == exp, "R7", "selection word", int'(logW[i]), int'(exp));
      acc ^= logW[i];
      i++;
    end
    for (int r = 0; r < rep; r++) begin
      for (int k = 0; k < len; k++) begin
        exp = pst[(dual && sel) ? calB[k] : calA[k]];
        if (logW[i] != exp) begin
          errs++;
          if (firstBad < 0) firstBad = i - s;
        end
        acc ^= logW[i];
        i++;
      end
    end
    check(errs == 0, "R5", "entry mismatches (count)", errs, 0);
    check(logW[i] == ~acc, "R6", "DIP word", int'(logW[i]), int'(~acc));
    i++;
    nxt = i;
  endtask

  task automatic checkPattern(input int s, input int n, input bit lvds, input string req);
    int errs = 0;
    logic [1:0] exp;
    for (int j = 0; j < n; j++) begin
      exp = (lvds && (j % 20) < 10) ? 2'b00 : 2'b11;
      if (logW[s + j] != exp) errs++;
    end
    check(errs == 0, req, "fill/training word mismatches (count)", errs, 0);
  endtask

  task automatic testMode();
    doReset(1'b0, 1'b0, 1'b0, 1'b0, 1, 1, 0, 1);
    @(negedge clk); #1 lvdsMode = 1'b1;
    @(negedge clk);
    check(modeFlag == 1'b1, "R1", "modeFlag after rise", int'(modeFlag), 1);
    #1 lvdsMode = 1'b0;
    @(negedge clk);
    check(modeFlag == 1'b0, "R1", "modeFlag after fall", int'(modeFlag), 0);
  endtask

  task automatic testTtlFill();
    doReset(1'b0, 1'b0, 1'b0, 1'b0, 4, 1, 0, 1);
    waitLog(100);
    checkPattern(0, 100, 1'b0, "R2");
  endtask

  task automatic testLvdsFill();
    doReset(1'b0, 1'b1, 1'b0, 1'b0, 4, 1, 0, 1);
    waitLog(45);
    #1 lvdsMode = 1'b0;
    waitLog(80);
    checkPattern(0, 20, 1'b0, "R10");
    check(logW[20] == 2'b00, "R3", "first training fill word", int'(logW[20]), 0);
    checkPattern(20, 40, 1'b1, "R3");
    checkPattern(60, 20, 1'b0, "R3");
  endtask

  task automatic testSingle();
    int fs, n1, n2;
    doReset(1'b1, 1'b0, 1'b0, 1'b1, 5, 3, 0, 1);
    waitLog(120);
    fs = frameStart(0);
    check(fs == 20, "R4", "first frame after fill unit", fs, 20);
    checkFrame(fs, 1'b0, 1'b1, 5, 3, n1);
    checkFrame(n1, 1'b0, 1'b1, 5, 3, n2);
    check(n2 == fs + 34, "R9", "back-to-back frames end", n2, fs + 34);
  endtask

  task automatic testDual(input bit sel);
    int fs, n1, n2;
    doReset(1'b1, 1'b0, 1'b1, sel, 8, 1, 0, 1);
    waitLog(80);
    fs = frameStart(0);
    checkFrame(fs, 1'b1, sel, 8, 1, n1);
    checkFrame(n1, 1'b1, sel, 8, 1, n2);
  endtask

  task automatic testLatch();
    int fs, n1, n2;
    doReset(1'b1, 1'b0, 1'b1, 1'b0, 4, 4, 0, 1);
    waitLog(26);
    #1 calSel = 1'b1; calLen = 5'd2;
    waitLog(80);
    fs = frameStart(0);
    // R8: the frame in progress keeps calendar 0 and length 4
    checkFrame(fs, 1'b1, 1'b0, 4, 4, n1);
    checkFrame(n1, 1'b1, 1'b1, 2, 4, n2);
  endtask

  task automatic testTrain();
    int fs, n1, n2, n3, n4;
    doReset(1'b1, 1'b0, 1'b0, 1'b0, 3, 1, 2, 2);
    waitLog(130);
    fs = frameStart(0);
    checkFrame(fs, 1'b0, 1'b0, 3, 1, n1);
    checkFrame(n1, 1'b0, 1'b0, 3, 1, n2);
    checkPattern(n2, 40, 1'b1, "R9");
    checkFrame(n2 + 40, 1'b0, 1'b0, 3, 1, n3);
    checkFrame(n3, 1'b0, 1'b0, 3, 1, n4);
    checkPattern(n4, 40, 1'b1, "R9");
  endtask

  task automatic testSyncBoundary();
    int fs, n1;
    doReset(1'b0, 1'b1, 1'b0, 1'b0, 4, 2, 0, 1);
    waitLog(50);
    #1 inSync = 1'b1;
    waitLog(66);
    #1 inSync = 1'b0;
    waitLog(100);
    fs = frameStart(50);
    check(fs == 60, "R4", "frame waits for unit end", fs, 60);
    checkPattern(40, 20, 1'b1, "R4");
    checkFrame(fs, 1'b0, 1'b0, 4, 2, n1);
    check(n1 == 70, "R4", "frame completes after sync loss", n1, 70);
    checkPattern(n1, 20, 1'b1, "R4");
  endtask

  initial begin
    for (int p = 0; p < NP; p++) pst[p] = 2'((p * 5 + 1) % 4);
    for (int k = 0; k < CM; k++) begin
      calA[k] = (k * 3 + 1) % NP;
      calB[k] = (k * 5 + 2) % NP;
    end
    testMode();
    testTtlFill();
    testLvdsFill();
    testSingle();
    testDual(1'b0);
    testDual(1'b1);
    testLatch();
    testTrain();
    testSyncBoundary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule